// File: doc/BRIEF.md
# Minifloat Sign-Magnitude Decimal Display Driver

This block takes a 6-bit minifloat word, held static on a set of switches, and shows its value as a signed two-digit decimal number on a four-position multiplexed seven-segment display. The word has a sign bit, a 2-bit exponent and a 3-bit significand. There is no implicit leading one. The magnitude is the significand shifted left by the exponent, so the values run from 0 to 56.

The magnitude goes through a combinational binary-to-BCD converter, which gives a tens digit and a units digit. Each digit is turned into an active-low segment pattern. A scan timer, derived from the system clock frequency parameter, enables one display position at a time in a fixed rotation. The leftmost position shows a minus bar for negative words. The next position is always blank. The last two positions show the tens and units digits.

The output register is updated on every clock. A switch change therefore appears on the lit position one clock later, with no need to wait for a scan boundary.

Top module: `mf_seg_display`

## Requirements
- R1: The input word is split as sign = `sw_word[5]`, exponent = `sw_word[4:3]`, significand = `sw_word[2:0]`.
- R2: The magnitude equals significand << exponent, with no implicit leading one. It lies in 0..56, and an all-zero significand gives 0 for any exponent.
- R3: The magnitude is split into decimal tens and units digits. Tens never exceeds 5 and units never exceeds 9.
- R4: Position 3 (`an_n[3]`, leftmost) shows only segment g (`seg_n` = 7'b0111111) when the sign is 1, and is blank (`seg_n` = 7'b1111111) when the sign is 0. Position 2 is always blank.
- R5: Position 1 shows the tens digit and position 0 shows the units digit. A tens digit of 0 is shown as 0. `seg_n[0]` is segment a and `seg_n[6]` is segment g, both active-low. The patterns in active-high gfedcba form are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F.
- R6: During reset, `an_n` = 4'b1111 and `seg_n` = 7'b1111111. From the first clock after reset, exactly one `an_n` bit is low.
- R7: The enabled position steps 3, 2, 1, 0 and then repeats, so `an_n` follows 0111, 1011, 1101, 1110. Position 3 is the first enabled after reset.
- R8: Each position stays enabled for exactly CLK_HZ/SCAN_HZ clock cycles.
- R9: A change on `sw_word` shows on `seg_n` for the currently enabled position one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_word | input | 6 | Minifloat word (sign, exponent, significand) |
| seg_n | output | 7 | Active-low segments, bit 0 = a through bit 6 = g |
| an_n | output | 4 | Active-low position enables, bit 3 = leftmost |

## Verification
The assertions check four things on every cycle:
- at most one enable is low;
- each enable change is the next step of the rotation;
- each position dwells for exactly the slot length;
- the internal magnitude and BCD digits stay in range, and the blank position stays dark.

Some behaviour only the bench scenarios can show. The bench sweeps all 64 words and decodes the displayed segments back to values, so it shows that each word gives the right decimal value and sign. It also shows the reset outputs and the one-clock response to a switch change in the middle of a slot.

// File: rtl/mf_disp_pkg.sv
package mf_disp_pkg;

    localparam int EXP_W = 2;
    localparam int SIG_W = 3;
    localparam int WORD_W = 1 + EXP_W + SIG_W;
    localparam int MAG_W = 7;
    localparam int POS_N = 4;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [SIG_W-1:0] sig;
    } mf_fields_t;

    localparam logic [6:0] SEG_DARK  = 7'b1111111;
    localparam logic [6:0] SEG_MINUS = 7'b0111111;

    function automatic logic [6:0] seg_of_digit(input logic [3:0] d);
        logic [6:0] hi;
        case (d)
            4'd0: hi = 7'h3F;
            4'd1: hi = 7'h06;
            4'd2: hi = 7'h5B;
            4'd3: hi = 7'h4F;
            4'd4: hi = 7'h66;
            4'd5: hi = 7'h6D;
            4'd6: hi = 7'h7D;
            4'd7: hi = 7'h07;
            4'd8: hi = 7'h7F;
            4'd9: hi = 7'h6F;
            default: hi = 7'h00;
        endcase
        return ~hi;
    endfunction

endpackage

// File: rtl/mf_field_decode.sv
module mf_field_decode
    import mf_disp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              sign,
    output logic [MAG_W-1:0]  mag
);

    mf_fields_t f;

    always_comb begin
        f    = mf_fields_t'(word);
        sign = f.sign;
        mag  = MAG_W'(f.sig) << f.expo;
    end

endmodule

// File: rtl/mf_bcd_split.sv
module mf_bcd_split
    import mf_disp_pkg::*;
(
    input  logic [MAG_W-1:0] mag,
    output logic [3:0]       tens,
    output logic [3:0]       units
);

    logic [7:0] acc;

    always_comb begin
        acc = '0;
        for (int i = MAG_W - 1; i >= 0; i--) begin
            if (acc[3:0] >= 4'd5) acc[3:0] = acc[3:0] + 4'd3;
            if (acc[7:4] >= 4'd5) acc[7:4] = acc[7:4] + 4'd3;
            acc = {acc[6:0], mag[i]};
        end
        tens  = acc[7:4];
        units = acc[3:0];
    end

endmodule

// File: rtl/mf_scan_timer.sv
module mf_scan_timer #(
    parameter int SLOT_CYC = 250000,
    parameter int POS_N    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic [$clog2(POS_N)-1:0] slot
);

    localparam int CW = (SLOT_CYC > 2) ? $clog2(SLOT_CYC) : 1;
    localparam int SW = $clog2(POS_N);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [SW-1:0] slot;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == CW'(SLOT_CYC - 1)) begin
            tmr_d.cnt  = '0;
            tmr_d.slot = tmr_q.slot + 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign slot = tmr_q.slot;

endmodule

// File: rtl/mf_seg_display.sv
module mf_seg_display
    import mf_disp_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int SCAN_HZ = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] sw_word,
    output logic [6:0] seg_n,
    output logic [3:0] an_n
);

    localparam int SLOT_CYC = CLK_HZ / SCAN_HZ;
    localparam int SW = $clog2(POS_N);

    typedef struct packed {
        logic [6:0]       seg;
        logic [POS_N-1:0] an;
    } drv_t;

    logic             sign_w;
    logic [MAG_W-1:0] mag_w;
    logic [3:0]       tens_w;
    logic [3:0]       units_w;
    logic [SW-1:0]    slot_w;
    logic [6:0]       pos_seg [POS_N];
    drv_t             drv_d, drv_q;

    mf_field_decode u_dec (
        .word (sw_word),
        .sign (sign_w),
        .mag  (mag_w)
    );

    mf_bcd_split u_bcd (
        .mag   (mag_w),
        .tens  (tens_w),
        .units (units_w)
    );

    mf_scan_timer #(
        .SLOT_CYC (SLOT_CYC),
        .POS_N    (POS_N)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot_w)
    );

    always_comb begin
        pos_seg[3] = sign_w ? SEG_MINUS : SEG_DARK;
        pos_seg[2] = SEG_DARK;
        pos_seg[1] = seg_of_digit(tens_w);
        pos_seg[0] = seg_of_digit(units_w);
    end

    always_comb begin
        logic [SW-1:0] pos;
        drv_d = drv_q;
        pos   = SW'(POS_N - 1) - slot_w;
        drv_d.seg = pos_seg[pos];
        drv_d.an  = ~(POS_N'(1) << pos);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q.seg <= SEG_DARK;
            drv_q.an  <= '1;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign seg_n = drv_q.seg;
    assign an_n  = drv_q.an;

endmodule

// File: rtl/mf_seg_display_chk.sv
module mf_seg_display_chk #(
    parameter int SLOT_CYC = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] seg_n,
    input logic [3:0] an_n,
    input logic [6:0] mag,
    input logic [3:0] tens,
    input logic [3:0] units
);

    logic [3:0]  last_q;
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 4'hF;
            run_q  <= '0;
        end else begin
            last_q <= an_n;
            run_q  <= (an_n != last_q) ? 32'd1 : run_q + 32'd1;
        end
    end

    a_r6_one_anode: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~an_n));

    a_r7_rotation: assert property (@(posedge clk) disable iff (!rst_n)
        (an_n != last_q && last_q != 4'hF) |-> an_n == {last_q[0], last_q[3:1]});

    a_r8_dwell: assert property (@(posedge clk) disable iff (!rst_n)
        (an_n != last_q && last_q != 4'hF) |-> run_q == SLOT_CYC);

    a_r2_mag_range: assert property (@(posedge clk) disable iff (!rst_n)
        mag <= 7'd56);

    a_r3_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        tens <= 4'd5 && units <= 4'd9);

    a_r4_blank_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (an_n == 4'b1011) |-> seg_n == 7'b1111111);

endmodule

bind mf_seg_display mf_seg_display_chk #(.SLOT_CYC(SLOT_CYC)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .seg_n (seg_n),
    .an_n  (an_n),
    .mag   (mag_w),
    .tens  (tens_w),
    .units (units_w)
);

// File: tb/test_mf_seg_display.sv
module test_mf_seg_display;

    localparam int CLK_HZ  = 4000;
    localparam int SCAN_HZ = 400;
    localparam int SLOT    = CLK_HZ / SCAN_HZ;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] sw_word = '0;
    logic [6:0] seg_n;
    logic [3:0] an_n;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mf_seg_display #(.CLK_HZ(CLK_HZ), .SCAN_HZ(SCAN_HZ)) i_mf_seg_display (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_word (sw_word),
        .seg_n   (seg_n),
        .an_n    (an_n)
    );

    function automatic logic [6:0] pat(input int d);
        logic [6:0] p;
        case (d)
            0: p = 7'b0111111;  1: p = 7'b0000110;  2: p = 7'b1011011;
            3: p = 7'b1001111;  4: p = 7'b1100110;  5: p = 7'b1101101;
            6: p = 7'b1111101;  7: p = 7'b0000111;  8: p = 7'b1111111;
            default: p = 7'b1101111;
        endcase
        return ~p;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [3:0] exp_an [4];
        exp_an[0] = 4'b0111; exp_an[1] = 4'b1011;
        exp_an[2] = 4'b1101; exp_an[3] = 4'b1110;

        repeat (3) @(negedge clk);
        check("R6 reset an_n", 32'(an_n), 32'hF);
        check("R6 reset seg_n", 32'(seg_n), 32'h7F);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 first position", 32'(an_n), 32'b0111);

        for (int w = 0; w < 64; w++) begin
            int mag, tens, units;
            logic [6:0] exp_seg [4];
            sw_word = 6'(w);
            mag   = (w & 7) << ((w >> 3) & 3);
            tens  = mag / 10;
            units = mag % 10;
            exp_seg[0] = w[5] ? 7'b0111111 : 7'h7F;
            exp_seg[1] = 7'h7F;
            exp_seg[2] = pat(tens);
            exp_seg[3] = pat(units);
            // wait for a fresh entry into the sign position
            begin
                logic [3:0] prev;
                prev = an_n;
                @(negedge clk);
                while (!(an_n == 4'b0111 && prev != 4'b0111)) begin
                    prev = an_n;
                    @(negedge clk);
                end
            end
            for (int p = 0; p < 4; p++) begin
                int run;
                logic [3:0] held;
                check("R7 rotation", 32'(an_n), 32'(exp_an[p]));
                if (p == 0) check("R1 R4 sign position", 32'(seg_n), 32'(exp_seg[p]));
                else if (p == 1) check("R4 blank position", 32'(seg_n), 32'(exp_seg[p]));
                else check("R2 R3 R5 digit position", 32'(seg_n), 32'(exp_seg[p]));
                held = an_n;
                run = 1;
                @(negedge clk);
                while (an_n == held && run < 4 * SLOT) begin
                    run++;
                    @(negedge clk);
                end
                if (w < 4) check("R8 dwell", 32'(run), 32'(SLOT));
                if (p == 3) check("R6 single enable", 32'($countones(~an_n)), 32'd1);
            end
        end

        // R9: change switches mid-slot while units position is lit
        sw_word = 6'b000000;
        while (an_n != 4'b1110) @(negedge clk);
        @(negedge clk);
        check("R9 before change", 32'(seg_n), 32'(pat(0)));
        sw_word = 6'b000111;
        @(negedge clk);
        check("R9 one clock later", 32'(seg_n), 32'(pat(7)));

        // R2: zero significand with the largest exponent still shows zero
        sw_word = 6'b011000;
        @(negedge clk);
        check("R2 zero significand", 32'(seg_n), 32'(pat(0)));

        finish_run();
    end

endmodule